// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of an external PHY over a two-wire serial link. It runs Clause 22 read and write frames. Software sees two 16-bit registers on a small synchronous bus. The command register holds the PHY address, the register number, a clock-range code, a direction flag and a busy flag. The data register holds the value to be sent, or the value captured from the PHY.

For a write, software first loads the data register. It then writes the command register with busy set and polls until busy reads 0. A read follows the same steps, and the data register then holds the PHY's answer. The serial clock comes from the system clock through one of several fixed divide ratios. The data line is driven through an output value, an output enable and an input.

A command written with busy at 0 sends no frame. It gives exactly one clock pulse, which a PHY may need before it leaves reset.

Top module: `mdio_master`

## Requirements
- R1: Register 0 (reg_addr = 0) is the command register. Bits 15:11 hold the PHY address, 10:6 the register number, 4:2 the clock-range code, bit 1 the direction (1 = write, 0 = read) and bit 0 busy. Bit 5 reads as 0, and a read returns the live busy bit with the stored fields.
- R2: Register 1 (reg_addr = 1) is the data register. Its value is sent as the data field of a write frame. It is replaced by the 16 captured bits at the end of a read frame.
- R3: A frame is 64 MDC periods, each bit sampled by the PHY on a rising MDC edge. The sequence is 32 ones, start 01, opcode (10 read, 01 write), PHY address then register number MSB first, turnaround and 16 data bits MSB first. A write drives every bit and sends turnaround 10. MDIO changes only while MDC is low.
- R4: In a read frame, MDIO is released (mdio_oe low) for the last 18 bit times, from the turnaround to the end. The 16 data bits are sampled on rising MDC edges.
- R5: Writing the command register with bit 0 set makes busy read 1. Busy returns to 0 in the same cycle as the last falling MDC edge of the frame.
- R6: Clock-range codes 0..5 give MDC periods of 16, 26, 42, 62, 102 and 124 system clocks. Codes 6 and 7 give 124. MDC is high for half the period.
- R7: While busy is 1, writes to either register are ignored. Neither the frame in progress nor the readback changes.
- R8: A command write with bit 0 clear stores the fields and leaves busy at 0. It produces exactly one MDC pulse, high for half the selected period, without driving MDIO.
- R9: After reset both registers read 0. While no frame or pulse is running, MDC is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Read value of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench keeps the default 32-bit preamble, so every frame has its full 64 bit times. All eight clock-range codes appear in the vector table. This covers the six real ratios and the fallback of the two unused codes to the slowest one, and the period is measured edge to edge each time. A bench-side PHY model drives the read data after falling MDC edges, which checks the sampling edge and the release of the line during turnaround. Directed cases cover a command and data rewrite in the middle of a frame, and the single pulse from an all-zero command.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOTAL = PRE_LEN + 32;
  localparam int IW = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(TOTAL - 1);
  localparam logic [IW-1:0] TA_BIT   = IW'(PRE_LEN + 14);
  localparam logic [IW-1:0] DAT_BIT  = IW'(PRE_LEN + 16);
  localparam logic [IW-1:0] HDR_BIT  = IW'(PRE_LEN);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_KICK} st_t;

  st_t st;
  logic [4:0] phy_q, reg_q;
  logic [2:0] cr_q;
  logic wr_q, busy_q, kick_q, mdc_q;
  logic [15:0] data_q, rx;
  logic [5:0] cnt, half_q;
  logic [IW-1:0] bit_idx;
  logic [31:0] sh;

  function automatic logic [5:0] half_of(input logic [2:0] code);
    case (code)
      3'd0: half_of = 6'd8;
      3'd1: half_of = 6'd13;
      3'd2: half_of = 6'd21;
      3'd3: half_of = 6'd31;
      3'd4: half_of = 6'd51;
      default: half_of = 6'd62;
    endcase
  endfunction

  wire cmd_wr = reg_we && !reg_addr && !busy_q;
  wire dat_wr = reg_we && reg_addr && !busy_q;
  wire tick   = (cnt == half_q - 6'd1);

  assign reg_rdata = reg_addr ? data_q : {phy_q, reg_q, 1'b0, cr_q, wr_q, busy_q};
  assign mdc       = mdc_q;
  assign mdio_o    = (st == S_FRAME) && ((bit_idx < HDR_BIT) || sh[31]);
  assign mdio_oe   = (st == S_FRAME) && (wr_q || (bit_idx < TA_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      phy_q <= '0; reg_q <= '0; cr_q <= '0;
      wr_q <= 1'b0; busy_q <= 1'b0; kick_q <= 1'b0; mdc_q <= 1'b0;
      data_q <= '0; rx <= '0; cnt <= '0; half_q <= 6'd8;
      bit_idx <= '0; sh <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          mdc_q <= 1'b0;
          if (busy_q) begin
            st <= S_FRAME;
            kick_q <= 1'b0;
            half_q <= half_of(cr_q);
            bit_idx <= '0;
            sh <= {2'b01, wr_q ? 2'b01 : 2'b10, phy_q, reg_q, 2'b10,
                   wr_q ? data_q : 16'h0000};
          end else if (kick_q) begin
            st <= S_KICK;
            kick_q <= 1'b0;
            half_q <= half_of(cr_q);
          end
        end
        S_FRAME: begin
          if (tick) begin
            cnt <= '0;
            if (!mdc_q) begin
              mdc_q <= 1'b1;
              if (!wr_q && bit_idx >= DAT_BIT) rx <= {rx[14:0], mdio_i};
            end else begin
              mdc_q <= 1'b0;
              if (bit_idx == LAST_BIT) begin
                st <= S_IDLE;
                busy_q <= 1'b0;
                if (!wr_q) data_q <= rx;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx >= HDR_BIT) sh <= {sh[30:0], 1'b0};
              end
            end
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            mdc_q <= !mdc_q;
            if (mdc_q) st <= S_IDLE;
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
      endcase
      if (cmd_wr) begin
        phy_q  <= reg_wdata[15:11];
        reg_q  <= reg_wdata[10:6];
        cr_q   <= reg_wdata[4:2];
        wr_q   <= reg_wdata[1];
        busy_q <= reg_wdata[0];
        if (!reg_wdata[0]) kick_q <= 1'b1;
      end
      if (dat_wr) data_q <= reg_wdata;
    end
  end
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        wr,
  input logic        reg_we,
  input logic [15:0] fields
);
  // R3
  mdo_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> !wr);
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));
  // R6
  mdc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |=> mdc);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> $stable(fields));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mdc) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy_q), .wr(wr_q), .reg_we(reg_we),
  .fields({phy_q, reg_q, cr_q, wr_q, data_q})
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  mdio_master dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = !clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // entry: code[45:43] wr[42] phy[41:37] reg[36:32] wdata[31:16] phyval[15:0]
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {3'd0, 1'b1, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
    {3'd1, 1'b0, 5'h1F, 5'h02, 16'h0000, 16'h8001},
    {3'd2, 1'b1, 5'h10, 5'h1F, 16'h0001, 16'h0000},
    {3'd3, 1'b0, 5'h05, 5'h11, 16'h0000, 16'h7FFE},
    {3'd4, 1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0000},
    {3'd5, 1'b0, 5'h00, 5'h01, 16'h0000, 16'h1234},
    {3'd6, 1'b1, 5'h15, 5'h0A, 16'h8000, 16'h0000},
    {3'd7, 1'b0, 5'h1B, 5'h04, 16'h0000, 16'hC3A5}
  };

  function automatic int period_of(input logic [2:0] c);
    case (c)
      3'd0: return 16; 3'd1: return 26; 3'd2: return 42;
      3'd3: return 62; 3'd4: return 102; default: return 124;
    endcase
  endfunction

  // monitor and PHY model
  logic mdc_prev = 1'b0;
  int rises = 0, last_rise = 0, per_min = 0, per_max = 0, high_len = 0, fall_cyc = 0;
  bit oe_seen = 0;
  logic cap_oe [64];
  logic cap_o [64];
  logic [15:0] phy_val = '0;
  always @(negedge clk) begin
    if (mdio_oe) oe_seen = 1;
    if (mdc && !mdc_prev) begin
      if (rises < 64) begin cap_oe[rises] = mdio_oe; cap_o[rises] = mdio_o; end
      if (rises > 0) begin
        if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      rises++;
    end
    if (!mdc && mdc_prev) begin
      high_len = cyc - last_rise;
      fall_cyc = cyc;
      if (rises >= 48 && rises <= 63) mdio_i = phy_val[63 - rises];
      else mdio_i = 1'b1;
    end
    mdc_prev = mdc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  int zero_cyc = 0;
  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(1'b0, v);
      if (!v[0]) begin zero_cyc = cyc; break; end
    end
  endtask

  task automatic clear_mon();
    rises = 0; per_min = 0; per_max = 0; oe_seen = 0;
  endtask

  function automatic logic [63:0] frame_of(input logic wr, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r, 2'b10, d};
  endfunction

  function automatic int frame_errs(input logic wr, input logic [63:0] f);
    int e = 0;
    for (int b = 0; b < 64; b++) begin
      if (!wr && b >= 46) begin
        if (cap_oe[b] !== 1'b0) e++;
      end else if (cap_oe[b] !== 1'b1 || cap_o[b] !== f[63 - b]) e++;
    end
    return e;
  endfunction

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [45:0] e;
    logic [15:0] cmd;
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd_reg(1'b0, v); check(v == 16'h0, "R9 cmd reset", v, 0);
    rd_reg(1'b1, v); check(v == 16'h0, "R9 data reset", v, 0);
    check(!mdc && !mdio_oe, "R9 idle lines", {mdc, mdio_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      phy_val = e[15:0];
      cmd = {e[41:37], e[36:32], 1'b0, e[45:43], e[42], 1'b1};
      if (e[42]) wr_reg(1'b1, e[31:16]);
      clear_mon();
      wr_reg(1'b0, cmd);
      rd_reg(1'b0, v);
      check(v == cmd, "R1 command readback with busy", v, cmd);
      wait_idle();
      repeat (4) @(negedge clk);
      check(rises == 64, "R3 MDC pulse count", rises, 64);
      errs = frame_errs(e[42], frame_of(e[42], e[41:37], e[36:32], e[31:16]));
      check(errs == 0, e[42] ? "R3 write frame bits" : "R4 read frame bits", errs, 0);
      check(per_min == period_of(e[45:43]) && per_max == per_min,
            "R6 MDC period", per_max, period_of(e[45:43]));
      check(high_len == period_of(e[45:43]) / 2, "R6 MDC high time", high_len,
            period_of(e[45:43]) / 2);
      check(zero_cyc == fall_cyc, "R5 busy clears at last fall", zero_cyc, fall_cyc);
      rd_reg(1'b1, v);
      check(v == (e[42] ? e[31:16] : e[15:0]), "R2 data register", v,
            e[42] ? e[31:16] : e[15:0]);
      check(!mdc && !mdio_oe, "R9 idle after frame", {mdc, mdio_oe}, 0);
    end

    // R7 writes during busy are ignored
    wr_reg(1'b1, 16'h5AA5);
    clear_mon();
    cmd = {5'h03, 5'h0C, 1'b0, 3'd0, 1'b1, 1'b1};
    wr_reg(1'b0, cmd);
    repeat (200) @(negedge clk);
    wr_reg(1'b0, 16'hFFFB);
    wr_reg(1'b1, 16'h0F0F);
    rd_reg(1'b0, v);
    check(v == cmd, "R7 command unchanged during busy", v, cmd);
    wait_idle();
    repeat (4) @(negedge clk);
    errs = frame_errs(1'b1, frame_of(1'b1, 5'h03, 5'h0C, 16'h5AA5));
    check(errs == 0 && rises == 64, "R7 frame intact", errs, 0);
    rd_reg(1'b1, v);
    check(v == 16'h5AA5, "R7 data unchanged", v, 16'h5AA5);

    // R8 all-zero command gives one MDC pulse
    clear_mon();
    wr_reg(1'b0, 16'h0000);
    rd_reg(1'b0, v);
    check(v == 16'h0000, "R8 busy stays clear", v, 0);
    repeat (100) @(negedge clk);
    check(rises == 1, "R8 single pulse", rises, 1);
    check(high_len == 8, "R8 pulse width", high_len, 8);
    check(!oe_seen, "R8 MDIO not driven", oe_seen, 0);
    check(!mdc, "R9 MDC low after pulse", mdc, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule